// File: doc/BRIEF.md
# Indirect Configuration and I/O Window Port

This block sits on a host register bus and turns accesses to two data windows into single downstream cycles, either configuration cycles or I/O-port cycles. Software first writes a target token into an address register. It then reads or writes the configuration window or the I/O window with a byte, halfword or word size. The block forms the downstream address from the token and the byte enables from the access size and the low host address bits. It holds the host in wait states until the downstream side acknowledges, and then returns the read data on the lanes that were accessed.

The token for configuration space carries the bus number in bits 23:16 and the device/function number in bits 15:8. The register number sits in bits 7:0, and its two low bits are always dropped. For I/O cycles the token is a 16-bit port number.

When consecutive cycles change type, the block inserts one idle turnaround clock before presenting the new request, so the downstream bus is never driven early. A configuration read of register 0 is an ordinary, side-effect-free read. Software may therefore still issue one as a dummy access to settle the cycle type.

Top module: `cfg_io_port`

## Requirements
- R1: After reset, hostWait and dsReq are low, the address register reads back 0, and the previous cycle type counts as configuration.
- R2: A host write to offset 0x064 loads the full 32-bit address register. A read of 0x064 returns it. Both complete with no wait state and start no downstream cycle.
- R3: An access to offset 0x068 starts exactly one configuration cycle (dsType=0) with dsAddr equal to the token with bits 31:24 and 1:0 cleared.
- R4: An access to offset 0x06C starts exactly one I/O cycle (dsType=1) with dsAddr equal to the token with bits 31:16 and 1:0 cleared.
- R5: Byte enables follow hostSize (0 = byte, 1 = halfword, 2 or 3 = word) and the lane taken from hostAddr[1:0]. A byte uses 1 << hostAddr[1:0]. A halfword uses 4'b0011 shifted left by 2*hostAddr[1]. A word uses 4'b1111.
- R6: For a window write, dsWr is 1 and dsWdata equals hostWdata with the bytes of disabled lanes zeroed. For a window read, dsWr is 0.
- R7: hostWait is high from the cycle a window access is presented until the cycle after dsAck, when it drops for one completion cycle. dsReq and its type, address, enables and data stay steady until dsAck.
- R8: A window read returns dsRdata with the bytes of disabled lanes zeroed on hostRdata during the completion cycle.
- R9: If dsAbort comes with dsAck on a configuration read, the enabled lanes of hostRdata are all ones. On an aborted I/O read they are zero.
- R10: If a window access has the same cycle type as the previous downstream cycle, dsReq rises in the first cycle after the access is accepted. If the type changes, dsReq rises in the second cycle.
- R11: A configuration read with a token whose low byte is zero behaves as an ordinary read. It leaves the address register unchanged, and a configuration access that follows it needs no turnaround.
- R12: Host accesses to any other offset complete with no wait state, read as 0, start no downstream cycle and do not change the address register.
- R13: dsReq is low in the cycle after dsAck, so two downstream cycles are always separated by at least one idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host access request, held until hostWait is low |
| hostWr | input | 1 | 1 = host write, 0 = host read |
| hostAddr | input | 12 | Host byte offset |
| hostSize | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| hostWdata | input | 32 | Host write data on its byte lanes |
| hostRdata | output | 32 | Host read data |
| hostWait | output | 1 | Host wait state |
| dsReq | output | 1 | Downstream request, held until dsAck |
| dsType | output | 1 | 0 = configuration cycle, 1 = I/O cycle |
| dsAddr | output | 32 | Downstream dword address |
| dsBe | output | 4 | Downstream byte enables |
| dsWr | output | 1 | Downstream write |
| dsWdata | output | 32 | Downstream write data |
| dsAck | input | 1 | Downstream completion, one cycle |
| dsRdata | input | 32 | Downstream read data, valid with dsAck |
| dsAbort | input | 1 | Downstream master-abort, valid with dsAck |

## Verification
The hardest state to reach is a window access that follows a cycle of the other type. In the same run, the cycle type must be tracked across address-register writes and dummy reads, because those change the turnaround delay of R10 and R11. The stimulus mixes configuration and I/O window accesses at random with address-register writes and stray offsets between them. It measures the delay from each accepted access to dsReq against a type history that the bench keeps itself. Aborts on both cycle types are forced in directed steps, and random acknowledge delays stretch the wait interval.

// File: rtl/cfg_io_pkg.sv
package cfg_io_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_REQ  = 2'd2,
    ST_DONE = 2'd3
  } state_t;

  typedef enum logic {
    CYC_CFG = 1'b0,
    CYC_IO  = 1'b1
  } cyc_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_t;

  // strobes from control to datapath
  typedef struct packed {
    logic idle;     // controller can take a new host access
    logic accept;   // latch the window access
    logic capture;  // latch downstream response
    logic done;     // completion cycle
  } ctrl_t;

  // decode status from datapath to control
  typedef struct packed {
    logic winHit;     // host addresses a data window
    logic typeSwitch; // that window differs from last cycle type
  } stat_t;

endpackage

// File: rtl/cfg_io_dp.sv
module cfg_io_dp
  import cfg_io_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] ADDR_OFS = 12'h064,
  parameter logic [ADDR_W-1:0] CFG_OFS  = 12'h068,
  parameter logic [ADDR_W-1:0] IO_OFS   = 12'h06C,
  parameter logic [DATA_W-1:0] CFG_KEEP = 32'h00FF_FFFC,
  parameter logic [DATA_W-1:0] IO_KEEP  = 32'h0000_FFFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [DATA_W-1:0] hostWdata,
  input  ctrl_t             ctrl,
  output stat_t             stat,
  output logic [DATA_W-1:0] hostRdata,
  output logic              dsType,
  output logic [DATA_W-1:0] dsAddr,
  output logic [DATA_W/8-1:0] dsBe,
  output logic              dsWr,
  output logic [DATA_W-1:0] dsWdata,
  input  logic [DATA_W-1:0] dsRdata,
  input  logic              dsAbort
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int IDX_W  = ADDR_W - LANE_W;

  logic [IDX_W-1:0]  wordIdx;
  logic              addrHit, cfgHit, ioHit;
  cyc_t              winType;
  logic [LANE_W-1:0] lane;
  logic [LANES-1:0]  beNext;
  logic [DATA_W-1:0] maskNext, maskReq;

  logic [DATA_W-1:0] tokenReg;
  cyc_t              lastType;
  cyc_t              reqType;
  logic [DATA_W-1:0] reqAddr;
  logic [LANES-1:0]  reqBe;
  logic              reqWr;
  logic [DATA_W-1:0] reqWdata;
  logic [DATA_W-1:0] readData;

  // ---------------- host decode ----------------
  assign wordIdx = hostAddr[ADDR_W-1:LANE_W];
  assign addrHit = hostSel && (wordIdx == ADDR_OFS[ADDR_W-1:LANE_W]);
  assign cfgHit  = hostSel && (wordIdx == CFG_OFS[ADDR_W-1:LANE_W]);
  assign ioHit   = hostSel && (wordIdx == IO_OFS[ADDR_W-1:LANE_W]);
  assign winType = ioHit ? CYC_IO : CYC_CFG;
  assign lane    = hostAddr[LANE_W-1:0];

  assign stat.winHit     = cfgHit || ioHit;
  assign stat.typeSwitch = (winType != lastType);

  // ---------------- byte enables ----------------
  always_comb begin
    case (size_t'(hostSize))
      SZ_BYTE: beNext = LANES'(1) << lane;
      SZ_HALF: beNext = LANES'(3) << {lane[LANE_W-1:1], 1'b0};
      default: beNext = '1;
    endcase
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : gLaneMask
      assign maskNext[g*8 +: 8] = {8{beNext[g]}};
      assign maskReq[g*8 +: 8]  = {8{reqBe[g]}};
    end
  endgenerate

  // ---------------- address register ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tokenReg <= '0;
    end else if (ctrl.idle && addrHit && hostWr) begin
      tokenReg <= hostWdata;
    end
  end

  // ---------------- request latch ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastType <= CYC_CFG;
      reqType  <= CYC_CFG;
      reqAddr  <= '0;
      reqBe    <= '0;
      reqWr    <= 1'b0;
      reqWdata <= '0;
    end else if (ctrl.accept) begin
      lastType <= winType;
      reqType  <= winType;
      reqAddr  <= tokenReg & ((winType == CYC_IO) ? IO_KEEP : CFG_KEEP);
      reqBe    <= beNext;
      reqWr    <= hostWr;
      reqWdata <= hostWdata & maskNext;
    end
  end

  // ---------------- response capture ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readData <= '0;
    end else if (ctrl.capture) begin
      if (reqWr) begin
        readData <= '0;
      end else if (dsAbort) begin
        readData <= (reqType == CYC_CFG) ? maskReq : '0;
      end else begin
        readData <= dsRdata & maskReq;
      end
    end
  end

  // ---------------- outputs ----------------
  always_comb begin
    if (ctrl.done) begin
      hostRdata = readData;
    end else if (addrHit && !hostWr) begin
      hostRdata = tokenReg;
    end else begin
      hostRdata = '0;
    end
  end

  assign dsType  = reqType;
  assign dsAddr  = reqAddr;
  assign dsBe    = reqBe;
  assign dsWr    = reqWr;
  assign dsWdata = reqWdata;

endmodule

// File: rtl/cfg_io_ctrl.sv
module cfg_io_ctrl
  import cfg_io_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  hostSel,
  input  stat_t stat,
  input  logic  dsAck,
  output ctrl_t ctrl,
  output logic  dsReq,
  output logic  hostWait
);

  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext    = state;
    ctrl         = '0;
    hostWait     = 1'b0;
    dsReq        = 1'b0;
    case (state)
      ST_IDLE: begin
        ctrl.idle = 1'b1;
        if (hostSel && stat.winHit) begin
          ctrl.accept = 1'b1;
          hostWait    = 1'b1;
          stateNext   = stat.typeSwitch ? ST_TURN : ST_REQ;
        end
      end
      ST_TURN: begin
        hostWait  = 1'b1;
        stateNext = ST_REQ;
      end
      ST_REQ: begin
        hostWait = 1'b1;
        dsReq    = 1'b1;
        if (dsAck) begin
          ctrl.capture = 1'b1;
          stateNext    = ST_DONE;
        end
      end
      default: begin
        ctrl.done = 1'b1;
        stateNext = ST_IDLE;
      end
    endcase
  end

endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
  import cfg_io_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostSel,
  input  logic                hostWr,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [1:0]          hostSize,
  input  logic [DATA_W-1:0]   hostWdata,
  output logic [DATA_W-1:0]   hostRdata,
  output logic                hostWait,
  output logic                dsReq,
  output logic                dsType,
  output logic [DATA_W-1:0]   dsAddr,
  output logic [DATA_W/8-1:0] dsBe,
  output logic                dsWr,
  output logic [DATA_W-1:0]   dsWdata,
  input  logic                dsAck,
  input  logic [DATA_W-1:0]   dsRdata,
  input  logic                dsAbort
);

  ctrl_t ctrl;
  stat_t stat;

  cfg_io_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostSel  (hostSel),
    .stat     (stat),
    .dsAck    (dsAck),
    .ctrl     (ctrl),
    .dsReq    (dsReq),
    .hostWait (hostWait)
  );

  cfg_io_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .hostSel   (hostSel),
    .hostWr    (hostWr),
    .hostAddr  (hostAddr),
    .hostSize  (hostSize),
    .hostWdata (hostWdata),
    .ctrl      (ctrl),
    .stat      (stat),
    .hostRdata (hostRdata),
    .dsType    (dsType),
    .dsAddr    (dsAddr),
    .dsBe      (dsBe),
    .dsWr      (dsWr),
    .dsWdata   (dsWdata),
    .dsRdata   (dsRdata),
    .dsAbort   (dsAbort)
  );

endmodule

// File: rtl/cfg_io_port_chk.sv
module cfg_io_port_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                hostWait,
  input logic                dsReq,
  input logic                dsType,
  input logic [DATA_W-1:0]   dsAddr,
  input logic [DATA_W/8-1:0] dsBe,
  input logic [DATA_W-1:0]   dsWdata,
  input logic                dsAck
);

  // request held until acknowledged
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    dsReq && !dsAck |=> dsReq);

  // request fields steady while waiting
  assert_req_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    dsReq && !dsAck |=> $stable(dsAddr) && $stable(dsBe) && $stable(dsType) && $stable(dsWdata));

  // host is stalled whenever a downstream cycle is open
  assert_wait_during_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    dsReq |-> hostWait);

  // byte enables are one, two or four lanes
  assert_be_shape_R5: assert property (@(posedge clk) disable iff (!rstN)
    dsReq |-> ($countones(dsBe) == 1 || $countones(dsBe) == 2 || $countones(dsBe) == 4));

  // configuration addresses are dword aligned with a clear top byte
  assert_cfg_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    dsReq && !dsType |-> dsAddr[1:0] == 2'b00 && dsAddr[31:24] == 8'h00);

  // I/O addresses stay inside the 16-bit port space
  assert_io_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    dsReq && dsType |-> dsAddr[31:16] == 16'h0000 && dsAddr[1:0] == 2'b00);

  // idle clock after every acknowledge
  assert_gap_after_ack_R13: assert property (@(posedge clk) disable iff (!rstN)
    dsReq && dsAck |=> !dsReq);

endmodule

bind cfg_io_port cfg_io_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostWait (hostWait),
  .dsReq    (dsReq),
  .dsType   (dsType),
  .dsAddr   (dsAddr),
  .dsBe     (dsBe),
  .dsWdata  (dsWdata),
  .dsAck    (dsAck)
);

// File: tb/sim_cfg_io_port.sv
module sim_cfg_io_port;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] OFS_ADDR = 12'h064;
  localparam logic [11:0] OFS_CFG  = 12'h068;
  localparam logic [11:0] OFS_IO   = 12'h06C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0;
  logic        hostWr = 1'b0;
  logic [11:0] hostAddr = '0;
  logic [1:0]  hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostWait;
  logic        dsReq;
  logic        dsType;
  logic [31:0] dsAddr;
  logic [3:0]  dsBe;
  logic        dsWr;
  logic [31:0] dsWdata;
  logic        dsAck = 1'b0;
  logic [31:0] dsRdata = '0;
  logic        dsAbort = 1'b0;

  int total = 0;
  int bad = 0;
  int abortMode = 0;   // 0 random, 1 force abort, 2 never abort
  logic [31:0] respData = '0;
  logic        respAbort = 1'b0;
  logic [31:0] tokenModel = '0;
  logic        lastTypeModel = 1'b0;

  // results of the last access
  logic [31:0] gotRdata;
  int          gotReqs;
  int          gotReqAt;
  logic [31:0] gotAddr;
  logic [3:0]  gotBe;
  logic        gotType;
  logic        gotWr;
  logic [31:0] gotWdata;
  int          gotCycles;

  cfg_io_port u0 (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostWait(hostWait), .dsReq(dsReq),
    .dsType(dsType), .dsAddr(dsAddr), .dsBe(dsBe), .dsWr(dsWr),
    .dsWdata(dsWdata), .dsAck(dsAck), .dsRdata(dsRdata), .dsAbort(dsAbort)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] beModel(input logic [1:0] size, input logic [1:0] low);
    case (size)
      2'd0: return 4'b0001 << low;
      2'd1: return 4'b0011 << (low[1] ? 2 : 0);
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] laneMask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  // downstream responder
  initial begin
    forever begin
      @(negedge clk);
      if (dsAck) begin
        dsAck = 1'b0;
        dsAbort = 1'b0;
      end else if (dsReq && ($urandom_range(0, 1) == 0)) begin
        respData = $urandom;
        case (abortMode)
          1: respAbort = 1'b1;
          2: respAbort = 1'b0;
          default: respAbort = ($urandom_range(0, 7) == 0);
        endcase
        dsRdata = respData;
        dsAbort = respAbort;
        dsAck = 1'b1;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic access(input logic wr, input logic [11:0] ofs, input logic [1:0] size,
                        input logic [31:0] wdata);
    logic prevReq;
    @(negedge clk);
    hostSel = 1'b1; hostWr = wr; hostAddr = ofs; hostSize = size; hostWdata = wdata;
    gotReqs = 0; gotReqAt = 0; gotCycles = 0; prevReq = 1'b0;
    forever begin
      @(negedge clk);
      gotCycles++;
      if (dsReq && !prevReq) begin
        gotReqs++;
        if (gotReqAt == 0) gotReqAt = gotCycles;
        gotAddr = dsAddr; gotBe = dsBe; gotType = dsType; gotWr = dsWr; gotWdata = dsWdata;
      end
      prevReq = dsReq;
      if (!hostWait || gotCycles > 60) break;
    end
    gotRdata = hostRdata;
    hostSel = 1'b0;
  endtask

  task automatic setToken(input logic [31:0] tok);
    access(1'b1, OFS_ADDR, 2'd2, tok);
    tokenModel = tok;
  endtask

  // window access with full model check
  task automatic winCheck(input logic isIo, input logic wr, input logic [1:0] low,
                          input logic [1:0] size, input logic [31:0] wdata);
    logic [3:0]  be;
    logic [31:0] expRd;
    int          expAt;
    be = beModel(size, low);
    expAt = (isIo != lastTypeModel) ? 2 : 1;
    access(wr, (isIo ? OFS_IO : OFS_CFG) | 12'(low), size, wdata);
    check(isIo ? "R4 one io cycle" : "R3 one cfg cycle", 32'(gotReqs), 32'd1);
    check("R10 req delay", 32'(gotReqAt), 32'(expAt));
    check(isIo ? "R4 io type" : "R3 cfg type", 32'(gotType), 32'(isIo));
    check(isIo ? "R4 io addr" : "R3 cfg addr", gotAddr,
          tokenModel & (isIo ? 32'h0000_FFFC : 32'h00FF_FFFC));
    check("R5 byte enables", 32'(gotBe), 32'(be));
    check("R6 write flag", 32'(gotWr), 32'(wr));
    if (wr) begin
      check("R6 write data", gotWdata, wdata & laneMask(be));
    end else begin
      if (respAbort) expRd = isIo ? 32'h0 : laneMask(be);
      else expRd = respData & laneMask(be);
      check(respAbort ? "R9 abort read" : "R8 read data", gotRdata, expRd);
    end
    lastTypeModel = isIo;
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 wait low", 32'(hostWait), 32'd0);
    check("R1 req low", 32'(dsReq), 32'd0);
    rstN = 1'b1;
    access(1'b0, OFS_ADDR, 2'd2, 32'h0);
    check("R1 token resets to zero", gotRdata, 32'h0);
    // R1: first config access needs no turnaround
    setToken(32'hA512_3467);
    winCheck(1'b0, 1'b0, 2'd0, 2'd2, 32'h0);

    // R2 address register
    setToken(32'hDEAD_BEEF);
    check("R2 write zero wait", 32'(gotCycles), 32'd1);
    check("R2 no downstream", 32'(gotReqs), 32'd0);
    access(1'b0, OFS_ADDR, 2'd2, 32'h0);
    check("R2 read back", gotRdata, 32'hDEAD_BEEF);

    // R5 every lane and size, R6 writes
    setToken(32'h0001_2A10);
    for (int s = 0; s < 4; s++)
      for (int l = 0; l < 4; l++)
        winCheck(1'b0, 1'b1, 2'(l), 2'(s), $urandom);

    // R9 forced aborts on both types
    abortMode = 1;
    winCheck(1'b0, 1'b0, 2'd2, 2'd1, 32'h0);
    winCheck(1'b1, 1'b0, 2'd1, 2'd0, 32'h0);
    winCheck(1'b0, 1'b0, 2'd0, 2'd2, 32'h0);
    abortMode = 2;
    winCheck(1'b1, 1'b0, 2'd3, 2'd0, 32'h0);

    // R11 dummy config read of register 0 after an I/O cycle
    setToken(32'h0000_1234);
    winCheck(1'b1, 1'b1, 2'd0, 2'd2, 32'h5555_AAAA);
    setToken(32'h0003_4800);
    winCheck(1'b0, 1'b0, 2'd0, 2'd2, 32'h0);
    access(1'b0, OFS_ADDR, 2'd2, 32'h0);
    check("R11 token kept after dummy", gotRdata, 32'h0003_4800);
    setToken(32'h0003_483C);
    winCheck(1'b0, 1'b1, 2'd1, 2'd0, 32'h0000_7700);
    check("R11 no turnaround after dummy", 32'(gotReqAt), 32'd1);

    // R12 stray offsets
    access(1'b1, 12'h070, 2'd2, 32'hFFFF_FFFF);
    check("R12 stray write zero wait", 32'(gotCycles), 32'd1);
    check("R12 stray write no cycle", 32'(gotReqs), 32'd0);
    access(1'b0, 12'h060, 2'd2, 32'h0);
    check("R12 stray read zero", gotRdata, 32'h0);
    access(1'b0, OFS_ADDR, 2'd2, 32'h0);
    check("R12 token untouched", gotRdata, 32'h0003_483C);

    // R7/R13 constrained random mix
    abortMode = 0;
    for (int n = 0; n < 300; n++) begin
      int pick;
      pick = $urandom_range(0, 9);
      if (pick == 0) begin
        setToken($urandom);
      end else if (pick == 1) begin
        access(1'b1, 12'h000 + 12'($urandom_range(0, 15) * 4), 2'd2, $urandom);
        if (hostAddr[11:2] == OFS_ADDR[11:2]) tokenModel = hostWdata;
        if (hostAddr[11:2] == OFS_CFG[11:2] || hostAddr[11:2] == OFS_IO[11:2])
          lastTypeModel = (hostAddr[11:2] == OFS_IO[11:2]);
      end else begin
        winCheck(pick[0], ($urandom_range(0, 1) == 1), 2'($urandom_range(0, 3)),
                 2'($urandom_range(0, 3)), $urandom);
        check("R7 completion within bound", 32'(gotCycles <= 60), 32'd1);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule